// File: doc/BRIEF.md
# Masked Address/Data Break Comparator

This block is one channel of an on-chip debug break unit. Software loads a break address, a per-bit address mask and a break data word through a small register port, then picks which of four bus sources the channel watches. Two sources are full-width buses: an instruction-side bus and a load/store-side bus. The other two are half-width memory data buses, called X and Y.

On each clock, the channel looks at the chosen source. If that source's valid strobe is high and every unmasked address bit equals the break address, the cycle is an address hit. When data comparison is enabled, the data lanes of the chosen source must also equal the break data word. The X memory bus is compared with the upper half of the break data word and the Y memory bus with the lower half. A full match produces a one-cycle break request on the following clock and sets a sticky match flag, which software clears by writing a one to it.

Register writes take effect on the clock edge. A bus cycle that shares a clock with a register write is therefore judged against the register values from before the write.

Top module: `brk_channel`

## Requirements
- R1: After reset, the address, mask, data and control registers all read zero, `break_req` is low and the match flag is clear.
- R2: A write with `reg_wr` high stores `reg_wdata` into the register chosen by `reg_idx` at the clock edge. `reg_rdata` shows the register chosen by `reg_idx` without a clock delay. The register indices are 0 = break address, 1 = address mask, 2 = break data, 3 = control. The control layout is: bit 0 = data-compare enable, bits 2:1 = source select, bit 8 = match flag. All other control bits read zero.
- R3: The address condition holds when `((bus_addr ^ break_addr) & ~mask) == 0`. A mask bit of 1 drops that address bit from the comparison, and a mask bit of 0 keeps it.
- R4: The source select picks the source: 00 = instruction bus, 01 = load/store bus, 10 = X memory, 11 = Y memory. Only the chosen source's valid strobe, address and data can cause a match. Activity on the other sources is ignored.
- R5: When the data-compare enable is 0, the address condition on a valid cycle of the chosen source is enough for a match.
- R6: With the instruction or load/store bus chosen and data compare on, all 32 data bits must equal the break data register.
- R7: With X memory chosen and data compare on, `xmem_data[15:0]` must equal break data bits 31:16. Break data bits 15:0 are ignored.
- R8: With Y memory chosen and data compare on, `ymem_data[15:0]` must equal break data bits 15:0. Break data bits 31:16 are ignored.
- R9: `break_req` is high in the one clock cycle after each matching valid cycle and low otherwise.
- R10: A match sets the sticky flag on the same edge that raises `break_req`. Writing control with bit 8 = 1 clears the flag, and writing bit 8 = 0 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag ends up set.
- R11: A bus cycle in the same clock as a register write is compared against the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ibus_valid | input | 1 | Instruction bus cycle valid |
| ibus_addr | input | 32 | Instruction bus address |
| ibus_data | input | 32 | Instruction bus data |
| lbus_valid | input | 1 | Load/store bus cycle valid |
| lbus_addr | input | 32 | Load/store bus address |
| lbus_data | input | 32 | Load/store bus data |
| xmem_valid | input | 1 | X memory cycle valid |
| xmem_addr | input | 32 | X memory address |
| xmem_data | input | 16 | X memory data |
| ymem_valid | input | 1 | Y memory cycle valid |
| ymem_addr | input | 32 | Y memory address |
| ymem_data | input | 16 | Y memory data |
| break_req | output | 1 | One-cycle break request |

## Verification
The match result passes through exactly one register. A bus cycle presented before clock edge N therefore shows on `break_req` and on the match flag (control bit 8) after edge N and before edge N+1. The bench drives each stimulus on a falling edge and checks both results on the next falling edge. Register contents have no extra read delay: a write lands at the next rising edge, and the bench reads `reg_rdata` combinationally a fraction of a cycle after the falling edge that follows. For the same-clock write case, the bench places the write and the bus cycle before the same rising edge and expects the old-value result one falling edge later.

// File: rtl/brk_pkg.sv
// Package: shared encodings for the break comparator channel.
// Assumes a 2-bit register index and a control word at least 9 bits wide.
package brk_pkg;

    // Source select encoding
    typedef enum logic [1:0] {
        SRC_IBUS = 2'b00,
        SRC_LBUS = 2'b01,
        SRC_XMEM = 2'b10,
        SRC_YMEM = 2'b11
    } brk_src_e;

    // Register indices
    localparam int          IDX_W    = 2;
    localparam logic [1:0]  IDX_ADDR = 2'd0;
    localparam logic [1:0]  IDX_MASK = 2'd1;
    localparam logic [1:0]  IDX_DATA = 2'd2;
    localparam logic [1:0]  IDX_CTRL = 2'd3;

    // Control field positions
    localparam int CTRL_DEN_BIT  = 0;
    localparam int CTRL_SRC_LSB  = 1;
    localparam int CTRL_FLAG_BIT = 8;

    // Data is split into this many lanes; half-width buses use one lane each
    localparam int BRK_LANES = 2;

endpackage

// File: rtl/brk_regs.sv
// Module: brk_regs
// Holds the break address, address mask, break data, control fields and the
// sticky match flag. Writes land at the clock edge; reads are combinational.
// Assumes REG_W >= ADDR_W, REG_W >= DATA_W and REG_W > CTRL_FLAG_BIT.
module brk_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [REG_W-1:0]  wdata,
    input  logic              hit_set,
    output logic [REG_W-1:0]  rdata,
    output logic [ADDR_W-1:0] brk_addr,
    output logic [ADDR_W-1:0] brk_mask,
    output logic [DATA_W-1:0] brk_data,
    output logic              cfg_den,
    output brk_src_e          cfg_src,
    output logic              flag
);

    logic ctrl_wr;
    logic unused_wdata_bits;

    assign ctrl_wr           = wr && (idx == IDX_CTRL);
    assign unused_wdata_bits = ^wdata;

    // Configuration registers: load on write strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_addr <= '0;
            brk_mask <= '0;
            brk_data <= '0;
            cfg_den  <= 1'b0;
            cfg_src  <= SRC_IBUS;
        end else if (wr) begin
            case (idx)
                IDX_ADDR: brk_addr <= wdata[ADDR_W-1:0];
                IDX_MASK: brk_mask <= wdata[ADDR_W-1:0];
                IDX_DATA: brk_data <= wdata[DATA_W-1:0];
                default: begin
                    cfg_den <= wdata[CTRL_DEN_BIT];
                    cfg_src <= brk_src_e'(wdata[CTRL_SRC_LSB +: 2]);
                end
            endcase
        end
    end

    // Sticky match flag: a match sets it, a write of one clears it, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit_set) begin
            flag <= 1'b1;
        end else if (ctrl_wr && wdata[CTRL_FLAG_BIT]) begin
            flag <= 1'b0;
        end
    end

    // Read mux: zero-extended view of the indexed register
    always_comb begin
        rdata = '0;
        case (idx)
            IDX_ADDR: rdata[ADDR_W-1:0] = brk_addr;
            IDX_MASK: rdata[ADDR_W-1:0] = brk_mask;
            IDX_DATA: rdata[DATA_W-1:0] = brk_data;
            default: begin
                rdata[CTRL_DEN_BIT]      = cfg_den;
                rdata[CTRL_SRC_LSB +: 2] = cfg_src;
                rdata[CTRL_FLAG_BIT]     = flag;
            end
        endcase
    end

endmodule

// File: rtl/brk_src_mux.sv
// Module: brk_src_mux
// Picks the valid strobe, address and data of the chosen source. Half-width
// memory data is placed on its own lane: X on the upper lane, Y on the lower.
// The lane enables tell the comparator which lanes take part.
// Assumes DATA_W is even and equal to BRK_LANES * HALF_W.
module brk_src_mux
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / BRK_LANES
) (
    input  brk_src_e              src,
    input  logic                  ibus_valid,
    input  logic [ADDR_W-1:0]     ibus_addr,
    input  logic [DATA_W-1:0]     ibus_data,
    input  logic                  lbus_valid,
    input  logic [ADDR_W-1:0]     lbus_addr,
    input  logic [DATA_W-1:0]     lbus_data,
    input  logic                  xmem_valid,
    input  logic [ADDR_W-1:0]     xmem_addr,
    input  logic [HALF_W-1:0]     xmem_data,
    input  logic                  ymem_valid,
    input  logic [ADDR_W-1:0]     ymem_addr,
    input  logic [HALF_W-1:0]     ymem_data,
    output logic                  sel_valid,
    output logic [ADDR_W-1:0]     sel_addr,
    output logic [DATA_W-1:0]     sel_data,
    output logic [BRK_LANES-1:0]  lane_en
);

    // Source selection and lane alignment
    always_comb begin
        case (src)
            SRC_IBUS: begin
                sel_valid = ibus_valid;
                sel_addr  = ibus_addr;
                sel_data  = ibus_data;
                lane_en   = '1;
            end
            SRC_LBUS: begin
                sel_valid = lbus_valid;
                sel_addr  = lbus_addr;
                sel_data  = lbus_data;
                lane_en   = '1;
            end
            SRC_XMEM: begin
                sel_valid = xmem_valid;
                sel_addr  = xmem_addr;
                sel_data  = {xmem_data, {HALF_W{1'b0}}};
                lane_en   = 2'b10;
            end
            default: begin
                sel_valid = ymem_valid;
                sel_addr  = ymem_addr;
                sel_data  = {{HALF_W{1'b0}}, ymem_data};
                lane_en   = 2'b01;
            end
        endcase
    end

endmodule

// File: rtl/brk_compare.sv
// Module: brk_compare
// Combinational match: masked address equality on a valid cycle, plus lane-wise
// data equality over the enabled lanes when data compare is on.
// Assumes DATA_W divides evenly into BRK_LANES lanes.
module brk_compare
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANE_W = DATA_W / BRK_LANES
) (
    input  logic                 sel_valid,
    input  logic [ADDR_W-1:0]    sel_addr,
    input  logic [DATA_W-1:0]    sel_data,
    input  logic [BRK_LANES-1:0] lane_en,
    input  logic [ADDR_W-1:0]    brk_addr,
    input  logic [ADDR_W-1:0]    brk_mask,
    input  logic [DATA_W-1:0]    brk_data,
    input  logic                 cfg_den,
    output logic                 hit
);

    logic [BRK_LANES-1:0] lane_eq;
    logic                 addr_ok;
    logic                 data_ok;

    // One equality comparator per data lane
    for (genvar g = 0; g < BRK_LANES; g++) begin : g_lane
        assign lane_eq[g] = (sel_data[g*LANE_W +: LANE_W] == brk_data[g*LANE_W +: LANE_W]);
    end

    // Unmasked address bits must all agree
    assign addr_ok = ((sel_addr ^ brk_addr) & ~brk_mask) == '0;

    // Lanes that are not enabled never block a data match
    assign data_ok = &(lane_eq | ~lane_en);

    // Final combinational hit
    assign hit = sel_valid && addr_ok && (!cfg_den || data_ok);

endmodule

// File: rtl/brk_channel.sv
// Module: brk_channel (top)
// One break channel: register file, source mux, comparator and the registered
// break request. A match on cycle N gives break_req high in cycle N+1 only.
// Assumes one synchronous clock domain for the register port and all buses.
module brk_channel
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    localparam int HALF_W = DATA_W / BRK_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ibus_valid,
    input  logic [ADDR_W-1:0] ibus_addr,
    input  logic [DATA_W-1:0] ibus_data,
    input  logic              lbus_valid,
    input  logic [ADDR_W-1:0] lbus_addr,
    input  logic [DATA_W-1:0] lbus_data,
    input  logic              xmem_valid,
    input  logic [ADDR_W-1:0] xmem_addr,
    input  logic [HALF_W-1:0] xmem_data,
    input  logic              ymem_valid,
    input  logic [ADDR_W-1:0] ymem_addr,
    input  logic [HALF_W-1:0] ymem_data,
    output logic              break_req
);

    logic [ADDR_W-1:0]    brk_addr_q;
    logic [ADDR_W-1:0]    brk_mask_q;
    logic [DATA_W-1:0]    brk_data_q;
    logic                 cfg_den;
    brk_src_e             cfg_src;
    logic                 match_flag;
    logic                 sel_valid;
    logic [ADDR_W-1:0]    sel_addr;
    logic [DATA_W-1:0]    sel_data;
    logic [BRK_LANES-1:0] lane_en;
    logic                 hit_now;
    logic                 break_q;

    brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .hit_set  (hit_now),
        .rdata    (reg_rdata),
        .brk_addr (brk_addr_q),
        .brk_mask (brk_mask_q),
        .brk_data (brk_data_q),
        .cfg_den  (cfg_den),
        .cfg_src  (cfg_src),
        .flag     (match_flag)
    );

    brk_src_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .src        (cfg_src),
        .ibus_valid (ibus_valid),
        .ibus_addr  (ibus_addr),
        .ibus_data  (ibus_data),
        .lbus_valid (lbus_valid),
        .lbus_addr  (lbus_addr),
        .lbus_data  (lbus_data),
        .xmem_valid (xmem_valid),
        .xmem_addr  (xmem_addr),
        .xmem_data  (xmem_data),
        .ymem_valid (ymem_valid),
        .ymem_addr  (ymem_addr),
        .ymem_data  (ymem_data),
        .sel_valid  (sel_valid),
        .sel_addr   (sel_addr),
        .sel_data   (sel_data),
        .lane_en    (lane_en)
    );

    brk_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .sel_valid (sel_valid),
        .sel_addr  (sel_addr),
        .sel_data  (sel_data),
        .lane_en   (lane_en),
        .brk_addr  (brk_addr_q),
        .brk_mask  (brk_mask_q),
        .brk_data  (brk_data_q),
        .cfg_den   (cfg_den),
        .hit       (hit_now)
    );

    // Break request register: one cycle after each matching cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            break_q <= 1'b0;
        end else begin
            break_q <= hit_now;
        end
    end

    assign break_req = break_q;

endmodule

// File: rtl/brk_channel_chk.sv
// Module: brk_channel_chk
// Temporal checks on the break channel, bound into brk_channel.
// Assumes the same clock and synchronous reset as the channel.
module brk_channel_chk
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              ibus_valid,
    input logic              lbus_valid,
    input logic              xmem_valid,
    input logic              ymem_valid,
    input logic [1:0]        src,
    input logic              den,
    input logic [ADDR_W-1:0] bar,
    input logic [ADDR_W-1:0] mask,
    input logic              hit,
    input logic              flag,
    input logic              break_req
);

    logic chosen_valid;
    logic ctrl_wr;
    logic unused_chk_bits;

    assign unused_chk_bits = ^reg_wdata;
    assign ctrl_wr         = reg_wr && (reg_idx == IDX_CTRL);

    // Valid strobe of the chosen source, rebuilt from the ports
    always_comb begin
        case (src)
            2'b00:   chosen_valid = ibus_valid;
            2'b01:   chosen_valid = lbus_valid;
            2'b10:   chosen_valid = xmem_valid;
            default: chosen_valid = ymem_valid;
        endcase
    end

    // R9 / R10: a break request always has the flag set with it
    assert_req_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        break_req |-> flag);

    // R4: no chosen valid means no break request next cycle
    assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !chosen_valid |=> !break_req);

    // R3 / R5: fully masked address with data compare off always breaks
    assert_full_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chosen_valid && (mask == '1) && !den) |=> break_req);

    // R10: clearing write without a match leaves the flag clear
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[CTRL_FLAG_BIT] && !hit) |=> !flag);

    // R10: no match and no control write keeps the flag unchanged
    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !ctrl_wr) |=> $stable(flag));

    // R2: an address write shows up in the register one edge later
    assert_addr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_idx == IDX_ADDR)) |=> (bar == $past(reg_wdata[ADDR_W-1:0])));

endmodule

bind brk_channel brk_channel_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .ibus_valid (ibus_valid),
    .lbus_valid (lbus_valid),
    .xmem_valid (xmem_valid),
    .ymem_valid (ymem_valid),
    .src        (cfg_src),
    .den        (cfg_den),
    .bar        (brk_addr_q),
    .mask       (brk_mask_q),
    .hit        (hit_now),
    .flag       (match_flag),
    .break_req  (break_req)
);

// File: tb/tb_brk_channel.sv
// Bench for brk_channel: sweeps sources, data-compare modes and address/data
// perturbations, with a shadow model of the requirements.
module tb_brk_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ib_v = 0, lb_v = 0, xm_v = 0, ym_v = 0;
    logic [31:0] ib_a = '0, lb_a = '0, xm_a = '0, ym_a = '0;
    logic [31:0] ib_d = '0, lb_d = '0;
    logic [15:0] xm_d = '0, ym_d = '0;
    logic        break_req;

    int errors = 0;
    int checks = 0;

    // Shadow registers
    logic [31:0] sh_bar = '0, sh_mask = '0, sh_bdr = '0;
    logic        sh_den = 0, sh_flag = 0;
    logic [1:0]  sh_sel = 0;
    logic [31:0] a_m, dflip, mis_a;
    logic        exp_h;

    always #2 clk = ~clk;   // 250 MHz

    brk_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ibus_valid(ib_v), .ibus_addr(ib_a), .ibus_data(ib_d),
        .lbus_valid(lb_v), .lbus_addr(lb_a), .lbus_data(lb_d),
        .xmem_valid(xm_v), .xmem_addr(xm_a), .xmem_data(xm_d),
        .ymem_valid(ym_v), .ymem_addr(ym_a), .ymem_data(ym_d),
        .break_req(break_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_hit();
        logic v; logic [31:0] a; logic dm;
        case (sh_sel)
            2'd0:    begin v = ib_v; a = ib_a; dm = (ib_d == sh_bdr); end
            2'd1:    begin v = lb_v; a = lb_a; dm = (lb_d == sh_bdr); end
            2'd2:    begin v = xm_v; a = xm_a; dm = (xm_d == sh_bdr[31:16]); end
            default: begin v = ym_v; a = ym_a; dm = (ym_d == sh_bdr[15:0]); end
        endcase
        return v && (((a ^ sh_bar) & ~sh_mask) == 32'h0) && (!sh_den || dm);
    endfunction

    // Register write with buses idle; starts and ends just after a falling edge
    task automatic wr_reg(logic [1:0] idx, logic [31:0] val);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0; reg_idx = 2'd3;
        case (idx)
            2'd0: sh_bar = val;
            2'd1: sh_mask = val;
            2'd2: sh_bdr = val;
            default: begin
                sh_den = val[0]; sh_sel = val[2:1];
                if (val[8]) sh_flag = 1'b0;
            end
        endcase
    endtask

    // One bus cycle as currently driven; checks the request and flag afterwards
    task automatic bus_step(string tag);
        exp_h = model_hit();
        reg_idx = 2'd3;
        @(negedge clk);
        chk(tag, {31'b0, break_req}, {31'b0, exp_h});
        sh_flag = sh_flag | exp_h;
        #1;
        chk({tag, " R10 flag"}, {31'b0, reg_rdata[8]}, {31'b0, sh_flag});
        ib_v = 0; lb_v = 0; xm_v = 0; ym_v = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            reg_idx = i[1:0]; #1;
            chk("R1 reset reg", reg_rdata, 32'h0);
        end
        chk("R1 reset break_req", {31'b0, break_req}, 32'h0);

        // R2: write and read back every register
        wr_reg(2'd0, 32'h9E37_79B9); reg_idx = 2'd0; #1; chk("R2 addr", reg_rdata, 32'h9E37_79B9);
        wr_reg(2'd1, 32'h0000_0001); reg_idx = 2'd1; #1; chk("R2 mask", reg_rdata, 32'h0000_0001);
        wr_reg(2'd2, 32'hA5C3_3C5A); reg_idx = 2'd2; #1; chk("R2 data", reg_rdata, 32'hA5C3_3C5A);
        wr_reg(2'd3, 32'hFFFF_FFFF); reg_idx = 2'd3; #1; chk("R2 ctrl", reg_rdata, 32'h0000_0007);

        // R4..R8: sweep sources, data-compare modes and perturbations
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                wr_reg(2'd3, 32'h100 | (s << 1) | e);
                for (int k = 0; k < 32; k++) begin
                    a_m   = sh_bar ^ (k[0] ? 32'h1 : 32'h0) ^ (k[1] ? 32'h8000_0000 : 32'h0);
                    dflip = (k[2] ? 32'h1 : 32'h0) ^ (k[3] ? 32'h8000 : 32'h0);
                    mis_a = a_m ^ 32'h100;
                    ib_v = 1; lb_v = 1; xm_v = 1; ym_v = 1;
                    ib_a = mis_a; lb_a = mis_a; xm_a = mis_a; ym_a = mis_a;
                    ib_d = sh_bdr ^ 32'h00F0_00F0; lb_d = ib_d;
                    xm_d = sh_bdr[31:16] ^ 16'h00F0; ym_d = sh_bdr[15:0] ^ 16'h00F0;
                    if (k[4]) begin
                        ib_a = sh_bar; lb_a = sh_bar; xm_a = sh_bar; ym_a = sh_bar;
                        ib_d = sh_bdr; lb_d = sh_bdr;
                        xm_d = sh_bdr[31:16]; ym_d = sh_bdr[15:0];
                        case (s)
                            0: ib_v = 0;
                            1: lb_v = 0;
                            2: xm_v = 0;
                            default: ym_v = 0;
                        endcase
                        tag = "R4 unselected";
                    end else begin
                        case (s)
                            0: begin ib_a = a_m; ib_d = sh_bdr ^ dflip; end
                            1: begin lb_a = a_m; lb_d = sh_bdr ^ dflip; end
                            2: begin xm_a = a_m; xm_d = sh_bdr[31:16] ^ dflip[15:0]; end
                            default: begin ym_a = a_m; ym_d = sh_bdr[15:0] ^ dflip[15:0]; end
                        endcase
                        if (e == 0)      tag = "R5 addr only";
                        else if (s < 2)  tag = "R6 full data";
                        else if (s == 2) tag = "R7 X upper half";
                        else             tag = "R8 Y lower half";
                    end
                    bus_step(tag);
                end
                wr_reg(2'd3, 32'h100 | (s << 1) | e);
                chk("R9 no repeat", {31'b0, break_req}, 32'h0);
            end
        end

        // R3: single-bit mask sweep on the instruction bus, address only
        wr_reg(2'd3, 32'h100);
        for (int b = 0; b < 32; b++) begin
            wr_reg(2'd1, 32'h1 << b);
            ib_v = 1; ib_a = sh_bar ^ (32'h1 << b);
            bus_step("R3 masked bit");
            ib_v = 1; ib_a = sh_bar ^ (32'h1 << ((b + 1) % 32));
            bus_step("R3 unmasked bit");
        end
        wr_reg(2'd1, 32'hFFFF_FFFF);
        ib_v = 1; ib_a = ~sh_bar;
        bus_step("R3 all masked");
        wr_reg(2'd1, 32'h0);

        // R9: back-to-back matches give back-to-back requests, then low
        wr_reg(2'd3, 32'h100);
        ib_v = 1; ib_a = sh_bar; bus_step("R9 first");
        ib_v = 1; ib_a = sh_bar; bus_step("R9 second");
        @(negedge clk);
        chk("R9 drops", {31'b0, break_req}, 32'h0);

        // R10: match and clearing write in the same cycle -> flag stays set
        wr_reg(2'd3, 32'h100);
        ib_v = 1; ib_a = sh_bar;
        reg_wr = 1; reg_idx = 2'd3; reg_wdata = 32'h100;
        @(negedge clk);
        reg_wr = 0; ib_v = 0; reg_idx = 2'd3; #1;
        chk("R10 set wins", {31'b0, reg_rdata[8]}, 32'h1);
        chk("R9 set-wins req", {31'b0, break_req}, 32'h1);
        @(negedge clk);
        wr_reg(2'd3, 32'h000); #1;
        chk("R10 write zero keeps", {31'b0, reg_rdata[8]}, 32'h1);
        @(negedge clk);
        wr_reg(2'd3, 32'h100); #1;
        chk("R10 write one clears", {31'b0, reg_rdata[8]}, 32'h0);
        @(negedge clk);

        // R11: bus cycle in the write clock uses the old address
        wr_reg(2'd0, 32'h1111_0000);
        ib_v = 1; ib_a = 32'h1111_0000;
        reg_wr = 1; reg_idx = 2'd0; reg_wdata = 32'h2222_0000;
        @(negedge clk);
        reg_wr = 0; ib_v = 0;
        chk("R11 old value", {31'b0, break_req}, 32'h1);
        sh_bar = 32'h2222_0000; sh_flag = 1'b1;
        ib_v = 1; ib_a = 32'h1111_0000; bus_step("R11 old gone");
        ib_v = 1; ib_a = 32'h2222_0000; bus_step("R11 new value");

        summary();
        $finish;
    end

endmodule